// File: doc/BRIEF.md
# Auto-Reloading Four-Channel DMA Address Sequencer

This block steps four independent memory-transfer channels for an audio path. Software programs each channel through a small byte-wide register port. A channel holds a 16-bit offset, a 16-bit transfer count, a page byte and a 6-bit mode. Sixteen-bit values are loaded one byte at a time, and a single low/high pointer that all channels share decides which byte a write lands in. Every offset and count write goes into a base copy and a working copy together.

A channel asks for service when its device request is high, it is unmasked and it is not in cascade mode. A channel in block mode also asks for service after its first grant until the burst ends. The block raises `hold_req`. Each cycle in which `hold_ack` is also high is one transfer. In that cycle the lowest-numbered eligible channel gets a one-hot acknowledge, the block drives the page and offset onto the memory address together with a read or write strobe, and the working offset and count of that channel advance. The transfer in which the count is zero is the terminal one. It pulses `tc_pulse`. An auto-initialising channel then restores its working registers from the base copies and keeps running. A single-cycle channel masks itself.

Register map (`reg_addr`): 0–3 offset of channel 0–3, 4–7 count of channel 0–3, 8–11 page of channel 0–3, 12 mask command, 13 mode command, 14 pointer clear, 15 reserved (writes ignored).

Top module: `dmac_top`

## Requirements
- R1: After reset all four channels are masked, `hold_req` is low and `dack` is zero, whatever `dreq` and `hold_ack` do.
- R2: A write to address 14 resets the shared byte pointer to low. Each write to an offset or count register (addresses 0–7, any channel) stores `reg_wdata` into the low byte when the pointer is low and into the high byte when it is high, and then flips the pointer. Offset and count writes of different channels share this one pointer.
- R3: During a transfer `mem_addr` equals {page, working offset} of the granted channel and is zero in other cycles. After the transfer the offset moves by +1 when mode bit 5 is 0 and by −1 when it is 1. It wraps within 16 bits and the page does not change.
- R4: A count value of N−1 gives N transfers. `tc_pulse` is high for exactly the transfer made while the working count is zero.
- R5: When mode bit 4 is 0, the terminal transfer sets the channel's mask, so the channel is not serviced again until a mask-clear write.
- R6: When mode bit 4 is 1, the terminal transfer reloads the working offset and count from the base copies, and the channel keeps being serviced.
- R7: A write to address 12 with `reg_wdata[7:3]` all zero sets (bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in bits 1:0. If any of bits 7:3 is set, the write is ignored.
- R8: A write to address 13 loads bits 7:2 into the mode of the channel in bits 1:0. In a transfer, mode bits 3:2 = 01 raise `mem_wr`, 10 raise `mem_rd`, and 00 or 11 raise neither strobe.
- R9: A channel whose mode bits 7:6 are 11 is never granted.
- R10: A channel whose mode bits 7:6 are 10 keeps requesting after its first grant, even with `dreq` low, until its terminal transfer, a mode write or a mask-set write.
- R11: Channel 0 has the highest priority and channel 3 the lowest. At most one `dack` bit is high, and only in a cycle with both `hold_req` and `hold_ack` high. Without `hold_ack` no register moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| dreq | input | 4 | Per-channel device request |
| hold_ack | input | 1 | Bus granted to this block for the current cycle |
| hold_req | output | 1 | At least one channel is eligible |
| dack | output | 4 | One-hot acknowledge of the channel transferring this cycle |
| mem_addr | output | PAGE_W+16 | Page and offset of the current transfer |
| mem_rd | output | 1 | Transfer reads from memory |
| mem_wr | output | 1 | Transfer writes to memory |
| tc_pulse | output | 1 | Current transfer is the terminal one |

## Verification
The bench builds the block with the default 8-bit page, which gives a 24-bit memory address and all four channels. Counts are drawn from zero to four, so terminal count, reload on auto-initialise and mask-on-finish each occur many times within a few dozen cycles. Offsets placed directly at 0x0000 and 0xFFFF reach the 16-bit wrap in both directions. Random mask bytes, mode bytes that include cascade and block, and random request and acknowledge patterns run against a reference model of every channel's registers.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CH_W   = 2;
  localparam int NCH    = 1 << CH_W;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    XS_DEMAND  = 2'd0,
    XS_SINGLE  = 2'd1,
    XS_BLOCK   = 2'd2,
    XS_CASCADE = 2'd3
  } xsel_e;

  typedef enum logic [1:0] {
    XK_VERIFY   = 2'd0,
    XK_TO_MEM   = 2'd1,
    XK_FROM_MEM = 2'd2,
    XK_BAD      = 2'd3
  } xkind_e;

  // mode byte bits 7:2, in bit order
  typedef struct packed {
    xsel_e  sel;
    logic   dec;
    logic   autoinit;
    xkind_e kind;
  } chmode_t;

  typedef enum logic [1:0] {PG_OFS, PG_CNT, PG_PAGE, PG_CTL} pgrp_e;
  typedef enum logic [1:0] {CT_MASK, CT_MODE, CT_CLRPTR, CT_RSVD} ctl_e;

  function automatic logic [OFS_W-1:0] ofs_step(input logic [OFS_W-1:0] o,
                                               input logic dec);
    return dec ? o - 1'b1 : o + 1'b1;
  endfunction

  function automatic logic [OFS_W-1:0] put_byte(input logic [OFS_W-1:0] old,
                                               input logic [BYTE_W-1:0] b,
                                               input logic hi);
    return hi ? {b, old[BYTE_W-1:0]} : {old[OFS_W-1:BYTE_W], b};
  endfunction
endpackage

// File: rtl/dmac_prio.sv
module dmac_prio
  import dmac_pkg::*;
(
  input  logic [NCH-1:0]  elig,
  output logic [NCH-1:0]  win,
  output logic [CH_W-1:0] win_idx,
  output logic            any
);
  always_comb begin
    win     = '0;
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        win_idx = CH_W'(i);
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ofs,
  input  logic              ld_cnt,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ld_page,
  input  logic              ld_mode,
  input  logic              ld_mask,
  input  logic              mask_val,
  input  logic              go,
  output logic [OFS_W-1:0]  ofs,
  output logic [PAGE_W-1:0] page,
  output chmode_t           mode,
  output logic              masked,
  output logic              burst,
  output logic              at_tc
);
  logic [OFS_W-1:0] base_ofs;
  logic [OFS_W-1:0] base_cnt;
  logic [OFS_W-1:0] cnt;
  logic             wr_this;

  assign wr_this = ld_ofs | ld_cnt | ld_page | ld_mode | ld_mask;
  assign at_tc   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_ofs <= '0;
      ofs      <= '0;
      base_cnt <= '0;
      cnt      <= '0;
      page     <= '0;
      mode     <= '0;
      masked   <= 1'b1;
      burst    <= 1'b0;
    end else if (wr_this) begin
      if (ld_ofs) begin
        base_ofs <= put_byte(base_ofs, wbyte, ld_hi);
        ofs      <= put_byte(ofs, wbyte, ld_hi);
      end
      if (ld_cnt) begin
        base_cnt <= put_byte(base_cnt, wbyte, ld_hi);
        cnt      <= put_byte(cnt, wbyte, ld_hi);
      end
      if (ld_page) page <= wbyte[PAGE_W-1:0];
      if (ld_mode) begin
        mode  <= chmode_t'(wbyte[7:2]);
        burst <= 1'b0;
      end
      if (ld_mask) begin
        masked <= mask_val;
        if (mask_val) burst <= 1'b0;
      end
    end else if (go) begin
      if (at_tc && mode.autoinit) begin
        ofs <= base_ofs;
        cnt <= base_cnt;
      end else begin
        ofs <= ofs_step(ofs, mode.dec);
        cnt <= cnt - 1'b1;
      end
      if (at_tc && !mode.autoinit) masked <= 1'b1;
      burst <= (mode.sel == XS_BLOCK) && !at_tc;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !at_tc && !wr_this |=> cnt == $past(cnt) - 1'b1);
  // R3
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !at_tc && !wr_this |=> ofs == ofs_step($past(ofs), $past(mode.dec)));
  // R5
  tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && at_tc && !mode.autoinit && !wr_this |=> masked);
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && at_tc && mode.autoinit && !wr_this |=> cnt == base_cnt && ofs == base_ofs);
  // R10
  burst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> mode.sel == XS_BLOCK && !masked);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [3:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  input  logic [3:0]              dreq,
  input  logic                    hold_ack,
  output logic                    hold_req,
  output logic [3:0]              dack,
  output logic [PAGE_W+15:0]      mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic                    tc_pulse
);
  localparam int MADDR_W = PAGE_W + OFS_W;

  pgrp_e           grp;
  ctl_e            ctl;
  logic [CH_W-1:0] rsel;
  logic [CH_W-1:0] csel;
  logic            hi_ptr;
  logic            wr_byte, wr_clr, wr_mask, wr_mode;

  assign grp  = pgrp_e'(reg_addr[3:2]);
  assign ctl  = ctl_e'(reg_addr[1:0]);
  assign rsel = reg_addr[CH_W-1:0];
  assign csel = reg_wdata[CH_W-1:0];

  assign wr_byte = reg_wr && (grp == PG_OFS || grp == PG_CNT);
  assign wr_clr  = reg_wr && grp == PG_CTL && ctl == CT_CLRPTR;
  assign wr_mask = reg_wr && grp == PG_CTL && ctl == CT_MASK && reg_wdata[7:3] == 5'd0;
  assign wr_mode = reg_wr && grp == PG_CTL && ctl == CT_MODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_ptr <= 1'b0;
    else if (wr_clr)  hi_ptr <= 1'b0;
    else if (wr_byte) hi_ptr <= ~hi_ptr;
  end

  logic [OFS_W-1:0]  ch_ofs  [NCH];
  logic [PAGE_W-1:0] ch_page [NCH];
  chmode_t           ch_mode [NCH];
  logic [NCH-1:0]    ch_masked, ch_burst, ch_tc, elig, win, go_vec;
  logic [CH_W-1:0]   widx;
  logic              any_elig, xfer;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmac_chan #(.PAGE_W(PAGE_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_ofs   (reg_wr && grp == PG_OFS && rsel == CH_W'(i)),
      .ld_cnt   (reg_wr && grp == PG_CNT && rsel == CH_W'(i)),
      .ld_hi    (hi_ptr),
      .wbyte    (reg_wdata),
      .ld_page  (reg_wr && grp == PG_PAGE && rsel == CH_W'(i)),
      .ld_mode  (wr_mode && csel == CH_W'(i)),
      .ld_mask  (wr_mask && csel == CH_W'(i)),
      .mask_val (reg_wdata[2]),
      .go       (go_vec[i]),
      .ofs      (ch_ofs[i]),
      .page     (ch_page[i]),
      .mode     (ch_mode[i]),
      .masked   (ch_masked[i]),
      .burst    (ch_burst[i]),
      .at_tc    (ch_tc[i])
    );
    assign elig[i] = !ch_masked[i] && ch_mode[i].sel != XS_CASCADE &&
                     (dreq[i] || ch_burst[i]);

    // R9
    cascade_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dack[i] |-> ch_mode[i].sel != XS_CASCADE);
  end

  dmac_prio u_prio (
    .elig    (elig),
    .win     (win),
    .win_idx (widx),
    .any     (any_elig)
  );

  assign xfer     = any_elig && hold_ack;
  assign go_vec   = xfer ? win : '0;
  assign hold_req = any_elig;
  assign dack     = go_vec;
  assign mem_addr = xfer ? MADDR_W'({ch_page[widx], ch_ofs[widx]}) : '0;
  assign mem_rd   = xfer && ch_mode[widx].kind == XK_FROM_MEM;
  assign mem_wr   = xfer && ch_mode[widx].kind == XK_TO_MEM;
  assign tc_pulse = xfer && ch_tc[widx];

  // R11
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  // R11
  dack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hold_ack && hold_req);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !hi_ptr);
  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte && !wr_clr |=> hi_ptr != $past(hi_ptr));
endmodule

// File: tb/dmac_top_test.sv
module dmac_top_test;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [3:0]    dreq = '0;
  logic          hold_ack = 1'b0;
  logic          hold_req;
  logic [3:0]    dack;
  logic [PW+15:0] mem_addr;
  logic          mem_rd, mem_wr, tc_pulse;

  always #4 clk = ~clk;

  dmac_top #(.PAGE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dreq(dreq), .hold_ack(hold_ack),
    .hold_req(hold_req), .dack(dack), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .tc_pulse(tc_pulse)
  );

  int vecs = 0;
  int errs = 0;

  // reference state
  logic [15:0] m_bofs [4];
  logic [15:0] m_ofs  [4];
  logic [15:0] m_bcnt [4];
  logic [15:0] m_cnt  [4];
  logic [7:0]  m_page [4];
  logic [5:0]  m_mode [4];
  logic        m_mask [4];
  logic        m_burst[4];
  logic        m_ptr;

  function automatic logic [15:0] setb(logic [15:0] o, logic [7:0] b, logic h);
    return h ? {b, o[7:0]} : {o[15:8], b};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_bofs[i] = '0; m_ofs[i] = '0; m_bcnt[i] = '0; m_cnt[i] = '0;
      m_page[i] = '0; m_mode[i] = '0; m_mask[i] = 1'b1; m_burst[i] = 1'b0;
    end
    m_ptr = 1'b0;
  endtask

  task automatic model_wr(logic [3:0] a, logic [7:0] d);
    int c;
    int k;
    c = int'(a[1:0]);
    k = int'(d[1:0]);
    case (a[3:2])
      2'd0: begin
        m_bofs[c] = setb(m_bofs[c], d, m_ptr);
        m_ofs[c]  = setb(m_ofs[c], d, m_ptr);
        m_ptr = ~m_ptr;
      end
      2'd1: begin
        m_bcnt[c] = setb(m_bcnt[c], d, m_ptr);
        m_cnt[c]  = setb(m_cnt[c], d, m_ptr);
        m_ptr = ~m_ptr;
      end
      2'd2: m_page[c] = d;
      default: begin
        if (a[1:0] == 2'd0 && d[7:3] == 5'd0) begin
          m_mask[k] = d[2];
          if (d[2]) m_burst[k] = 1'b0;
        end else if (a[1:0] == 2'd1) begin
          m_mode[k] = d[7:2];
          m_burst[k] = 1'b0;
        end else if (a[1:0] == 2'd2) begin
          m_ptr = 1'b0;
        end
      end
    endcase
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; dreq = '0; hold_ack = 1'b0;
    model_wr(a, d);
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic prog(logic [1:0] c, logic [7:0] md, logic [15:0] ad,
                      logic [15:0] n, logic [7:0] pg);
    wr(4'hC, 8'h04 | {6'd0, c});
    wr(4'hE, 8'h00);
    wr(4'hD, md | {6'd0, c});
    wr({2'b00, c}, ad[7:0]);
    wr({2'b00, c}, ad[15:8]);
    wr({2'b01, c}, n[7:0]);
    wr({2'b01, c}, n[15:8]);
    wr({2'b10, c}, pg);
    wr(4'hC, {6'd0, c});
  endtask

  task automatic step(logic [3:0] rq, logic ack, string tag);
    logic [3:0]  el;
    int          w;
    logic        xf, tcv, ai;
    logic [31:0] exp_v, got_v;
    logic [23:0] e_addr;
    logic [3:0]  e_dack;
    @(negedge clk);
    dreq = rq; hold_ack = ack; reg_wr = 1'b0;
    #1;
    w = 0;
    for (int i = 3; i >= 0; i--) begin
      el[i] = !m_mask[i] && m_mode[i][5:4] != 2'd3 && (rq[i] || m_burst[i]);
      if (el[i]) w = i;
    end
    xf = (|el) && ack;
    e_dack = '0;
    e_addr = '0;
    tcv = 1'b0;
    if (xf) begin
      e_dack[w] = 1'b1;
      e_addr = {m_page[w], m_ofs[w]};
      tcv = (m_cnt[w] == 16'd0);
    end
    exp_v = {|el, e_dack, e_addr, xf && m_mode[w][1:0] == 2'd2,
             xf && m_mode[w][1:0] == 2'd1, tcv};
    got_v = {hold_req, dack, mem_addr, mem_rd, mem_wr, tc_pulse};
    vecs++;
    if (got_v !== exp_v) begin
      errs++;
      $display("FAIL %s: {req,dack,addr,rd,wr,tc} actual=%h expected=%h", tag, got_v, exp_v);
    end
    if (xf) begin
      ai = m_mode[w][2];
      if (tcv && ai) begin
        m_ofs[w] = m_bofs[w];
        m_cnt[w] = m_bcnt[w];
      end else begin
        m_ofs[w] = m_mode[w][3] ? m_ofs[w] - 16'd1 : m_ofs[w] + 16'd1;
        m_cnt[w] = m_cnt[w] - 16'd1;
      end
      if (tcv && !ai) m_mask[w] = 1'b1;
      m_burst[w] = (m_mode[w][5:4] == 2'd2) && !tcv;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL R11: watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seedv;
    logic [1:0] c;
    logic [1:0] sel;
    int r;
    seedv = $urandom(32'd4242);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, everything masked
    step(4'hF, 1'b1, "R1");
    step(4'hF, 1'b0, "R1");

    // R4 / R3: three transfers from 5A:1234, read from memory, single-cycle
    prog(2'd1, 8'h48, 16'h1234, 16'd2, 8'h5A);
    for (int i = 0; i < 3; i++) step(4'b0010, 1'b1, "R4");
    // R5: masked after terminal count
    step(4'b0010, 1'b1, "R5");
    step(4'b0010, 1'b1, "R5");
    wr(4'hC, 8'h01);
    step(4'b0010, 1'b1, "R5");

    // R2: shared pointer, clear resets it
    wr(4'hE, 8'h00);
    wr(4'h1, 8'h77);
    wr(4'hE, 8'h00);
    wr(4'h1, 8'h00);
    wr(4'h1, 8'h80);
    step(4'b0010, 1'b1, "R2");
    wr(4'hE, 8'h00);
    wr(4'h1, 8'h11);
    wr(4'h5, 8'h22);
    step(4'b0010, 1'b1, "R2");
    wr(4'hC, 8'h05);

    // R6: auto-initialise, two transfers per pass
    prog(2'd0, 8'h58, 16'h0010, 16'd1, 8'h03);
    for (int i = 0; i < 5; i++) step(4'b0001, 1'b1, "R6");

    // R3: decrement wrap and increment wrap inside page
    prog(2'd3, 8'h68, 16'h0000, 16'd1, 8'hC4);
    for (int i = 0; i < 3; i++) step(4'b1000, 1'b1, "R3");
    prog(2'd3, 8'h48, 16'hFFFF, 16'd1, 8'hC4);
    for (int i = 0; i < 3; i++) step(4'b1000, 1'b1, "R3");

    // R7: mask byte with upper bits set is ignored
    prog(2'd2, 8'h48, 16'h0200, 16'd9, 8'h10);
    wr(4'hC, 8'h86);
    step(4'b0100, 1'b1, "R7");
    wr(4'hC, 8'h06);
    step(4'b0100, 1'b1, "R7");
    wr(4'hC, 8'h02);
    step(4'b0100, 1'b1, "R7");

    // R8: transfer kinds
    wr(4'hD, 8'h46);
    step(4'b0100, 1'b1, "R8");
    wr(4'hD, 8'h42);
    step(4'b0100, 1'b1, "R8");
    wr(4'hD, 8'h4E);
    step(4'b0100, 1'b1, "R8");

    // R9: cascade never served
    wr(4'hD, 8'hC2);
    step(4'b0100, 1'b1, "R9");
    step(4'b0100, 1'b1, "R9");

    // R10: block mode continues after request drops
    prog(2'd2, 8'h88, 16'h0300, 16'd3, 8'h20);
    step(4'b0100, 1'b1, "R10");
    step(4'b0000, 1'b0, "R10");
    for (int i = 0; i < 4; i++) step(4'b0000, 1'b1, "R10");

    // R11: priority and gating by acknowledge
    prog(2'd2, 8'h08, 16'h0400, 16'd7, 8'h21);
    step(4'b0101, 1'b1, "R11");
    step(4'b0101, 1'b0, "R11");
    step(4'b0100, 1'b1, "R11");
    step(4'b0101, 1'b1, "R11");

    // random mix
    for (int rnd = 0; rnd < 12; rnd++) begin
      c = 2'($urandom % 4);
      r = int'($urandom % 8);
      sel = (r < 6) ? 2'(r % 3) : 2'd3;
      prog(c, {sel, 1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4), 2'b00},
           16'($urandom), 16'($urandom % 5), 8'($urandom));
      for (int k = 0; k < 40; k++) begin
        if (k % 13 == 12) wr(4'hC, 8'($urandom));
        step(4'($urandom), ($urandom % 4) != 0, "R11");
      end
    end

    finish_run();
  end
endmodule